// File: doc/BRIEF.md
# Indexed Block-Transfer Register Slave for a Two-Wire Bus

This block is a target on a two-wire serial bus of the SMBus/I2C family. It holds a small bank of byte-wide configuration registers. A host reaches them through indexed block transfers. Both bus lines are oversampled by a faster system clock. The block finds start, repeated start and stop conditions on the sampled lines. It decodes its own 7-bit address and acknowledges or returns data by pulling SDA low through an open-drain enable. The contents of every register are also presented in parallel on a wide output bus, so the rest of the chip sees configuration changes directly.

A write transfer carries three things after the address: a register index, a byte count, and then that many data bytes. These are stored at consecutive register positions. A read first sets the index with a short write phase. The host then issues a repeated start and the read address. The slave answers with the value of the count register, followed by register bytes starting at the index. It keeps sending for as long as the host acknowledges.

Top module: `smb_blk_slave`

## Requirements
- R1: The slave acknowledges address byte 0xD4 (7-bit address 0x6A, R/W bit 0 = write) and 0xD5 (R/W bit 1 = read) by holding SDA low through the ninth SCL pulse.
- R2: Any other address byte gets no acknowledge. The slave then leaves SDA released and ignores every byte until the next start or stop.
- R3: In a write, the first byte after the address is the index and the second is the byte count; each is acknowledged. The data bytes that follow are stored at index, index+1, and so on, and each is acknowledged.
- R4: Data bytes beyond the byte count are not acknowledged and not stored. After such a byte the slave stays off the bus until the next start or stop.
- R5: The register position advances modulo 16, so the position after register 15 is register 0. This holds for both writes and reads.
- R6: After 0xD5 is acknowledged, the slave first sends the value of register 8 (the count register), then registers from the current index upward, each byte MSB first.
- R7: The slave sends another byte after each host acknowledge. After a host not-acknowledge it sends nothing more and keeps SDA released.
- R8: Register 8 is writable like any other register, and its value is the count the slave returns at the start of a read.
- R9: The slave changes its SDA drive only while SCL is low, and it takes received bits at the rising edge of SCL.
- R10: A stop or start in the middle of a byte aborts the transfer. Registers already written keep their values. A start always begins a fresh address phase.
- R11: After reset all registers read zero and SDA is released.
- R12: Register i appears on `regs_o[8*i+7:8*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low |
| regs_o | output | NREG*8 | All register contents, register i in byte lane i |

## Verification
The hardest case to reach is a transfer cut off in the middle of a byte, after some data bytes have already been stored. The stimulus gets there by sending a valid address, index, count and one data byte. It then clocks only part of the next byte and issues a stop, or in a second scenario a repeated start. The check confirms that the stored byte survives, that the partial byte changed nothing, and that the next transfer is accepted normally. A related corner is sending more data bytes than the count allows. The bench drives one extra byte and watches for the missing acknowledge and the untouched neighbouring register.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;

    // bit-level engine state
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for a start
        ST_RX,      // shifting in a byte from the host
        ST_RACK,    // slave-driven acknowledge slot
        ST_TX,      // shifting out a byte to the host
        ST_TACK,    // host-driven acknowledge slot
        ST_IGNORE   // off the bus until start or stop
    } smb_st_e;

    // meaning of the byte currently being received
    typedef enum logic [2:0] {
        RL_ADDR,
        RL_INDEX,
        RL_COUNT,
        RL_DATA,
        RL_READ
    } smb_role_e;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;   // idle bus is high
        else        sh_q <= sh_d;
    end

    assign lvl_o  = sh_q[STAGES-1];
    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
    parameter int NREG = 16,
    parameter int IDXW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDXW-1:0]   waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [IDXW-1:0]   raddr_i,
    output logic [7:0]        rdata_o,
    output logic [NREG*8-1:0] flat_o
);
    logic [7:0] mem_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [7:0] cell_d;
        always_comb begin
            cell_d = mem_q[g];
            if (we_i && (waddr_i == IDXW'(g))) cell_d = wdata_i;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= '0;
            else        mem_q[g] <= cell_d;
        end
        assign flat_o[g*8 +: 8] = mem_q[g];
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/smb_blk_slave.sv
module smb_blk_slave
    import smb_blk_pkg::*;
#(
    parameter logic [6:0] ADDR7       = 7'h6A,
    parameter int         NREG        = 16,
    parameter int         CNT_IDX     = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [NREG*8-1:0] regs_o
);
    localparam int              IDXW    = $clog2(NREG);
    localparam logic [IDXW-1:0] CNT_SEL = IDXW'(CNT_IDX);
    localparam logic [IDXW-1:0] LAST    = IDXW'(NREG - 1);

    typedef struct packed {
        smb_st_e         st;
        smb_role_e       role;
        logic [3:0]      bitcnt;
        logic [7:0]      shreg;
        logic [7:0]      txreg;
        logic [IDXW-1:0] idx;
        logic [7:0]      remain;
        logic            ack_now;
        logic            sda_oe;
    } slv_s;

    slv_s s_d, s_q;

    // line conditioning, one identical chain per line
    logic [1:0] raw_w, lvl_w, rise_w, fall_w;
    assign raw_w = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        smb_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw_w[g]),
            .lvl_o (lvl_w[g]),
            .rise_o(rise_w[g]),
            .fall_o(fall_w[g])
        );
    end

    logic scl_lvl, scl_rise, scl_fall, sda_lvl;
    logic start_evt, stop_evt;
    assign scl_lvl   = lvl_w[0];
    assign scl_rise  = rise_w[0];
    assign scl_fall  = fall_w[0];
    assign sda_lvl   = lvl_w[1];
    // SDA edge while SCL is steadily high marks a bus condition
    assign start_evt = fall_w[1] & scl_lvl & ~scl_rise;
    assign stop_evt  = rise_w[1] & scl_lvl & ~scl_rise;

    // register bank
    logic            wr_en;
    logic [IDXW-1:0] rd_addr;
    logic [7:0]      rd_data;

    smb_regfile #(.NREG(NREG), .IDXW(IDXW)) i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (wr_en),
        .waddr_i(s_q.idx),
        .wdata_i(s_q.shreg),
        .raddr_i(rd_addr),
        .rdata_o(rd_data),
        .flat_o (regs_o)
    );

    function automatic logic [IDXW-1:0] next_idx(input logic [IDXW-1:0] i);
        return (i == LAST) ? '0 : i + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        wr_en   = 1'b0;
        rd_addr = (s_q.st == ST_RACK) ? CNT_SEL : s_q.idx;

        if (stop_evt) begin
            s_d.st     = ST_IDLE;
            s_d.sda_oe = 1'b0;
        end else if (start_evt) begin
            s_d.st     = ST_RX;
            s_d.role   = RL_ADDR;
            s_d.bitcnt = '0;
            s_d.sda_oe = 1'b0;
        end else begin
            unique case (s_q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        s_d.shreg  = {s_q.shreg[6:0], sda_lvl};
                        s_d.bitcnt = s_q.bitcnt + 4'd1;
                    end else if (scl_fall && s_q.bitcnt == 4'd8) begin
                        s_d.bitcnt = '0;
                        s_d.st     = ST_RACK;
                        s_d.sda_oe = 1'b1;
                        unique case (s_q.role)
                            RL_ADDR: begin
                                if (s_q.shreg[7:1] == ADDR7)
                                    s_d.role = s_q.shreg[0] ? RL_READ : RL_INDEX;
                                else begin
                                    s_d.st     = ST_IGNORE;
                                    s_d.sda_oe = 1'b0;
                                end
                            end
                            RL_INDEX: begin
                                s_d.idx  = s_q.shreg[IDXW-1:0];
                                s_d.role = RL_COUNT;
                            end
                            RL_COUNT: begin
                                s_d.remain = s_q.shreg;
                                s_d.role   = RL_DATA;
                            end
                            RL_DATA: begin
                                if (s_q.remain != 8'd0) begin
                                    wr_en      = 1'b1;
                                    s_d.idx    = next_idx(s_q.idx);
                                    s_d.remain = s_q.remain - 8'd1;
                                end else begin
                                    s_d.st     = ST_IGNORE;
                                    s_d.sda_oe = 1'b0;
                                end
                            end
                            default: begin
                                s_d.st     = ST_IGNORE;
                                s_d.sda_oe = 1'b0;
                            end
                        endcase
                    end
                end
                ST_RACK: begin
                    if (scl_fall) begin
                        s_d.bitcnt = '0;
                        if (s_q.role == RL_READ) begin
                            s_d.txreg  = rd_data;        // count register first
                            s_d.sda_oe = ~rd_data[7];
                            s_d.st     = ST_TX;
                        end else begin
                            s_d.sda_oe = 1'b0;
                            s_d.st     = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        s_d.bitcnt = s_q.bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (s_q.bitcnt == 4'd8) begin
                            s_d.st      = ST_TACK;
                            s_d.sda_oe  = 1'b0;
                            s_d.bitcnt  = '0;
                            s_d.ack_now = 1'b0;
                        end else begin
                            s_d.txreg  = {s_q.txreg[6:0], 1'b0};
                            s_d.sda_oe = ~s_q.txreg[6];
                        end
                    end
                end
                ST_TACK: begin
                    if (scl_rise) begin
                        s_d.ack_now = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (s_q.ack_now) begin
                            s_d.txreg  = rd_data;
                            s_d.sda_oe = ~rd_data[7];
                            s_d.idx    = next_idx(s_q.idx);
                            s_d.st     = ST_TX;
                        end else begin
                            s_d.st = ST_IGNORE;
                        end
                    end
                end
                default: ;   // ST_IDLE, ST_IGNORE wait for a bus condition
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, role: RL_ADDR, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    smb_st_e cur_st;
    assign cur_st   = s_q.st;
    assign sda_oe_o = s_q.sda_oe;
endmodule

// File: rtl/smb_blk_chk.sv
module smb_blk_chk
    import smb_blk_pkg::*;
#(
    parameter int NREG = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_lvl,
    input logic              start_evt,
    input logic              stop_evt,
    input logic              sda_oe,
    input logic              wr_en,
    input logic [NREG*8-1:0] regs,
    input smb_st_e           st
);
    // R9: drive changes follow a sampled low SCL (bus conditions excepted)
    a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> (!$past(scl_lvl) || $past(start_evt) || $past(stop_evt)));

    // R2: while ignoring the bus, SDA stays released
    a_r2_quiet_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IGNORE) |-> !sda_oe);

    // R10: a stop returns the engine to idle with SDA released
    a_r10_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (st == ST_IDLE) && !sda_oe);

    // R10: a start always opens a new receive phase
    a_r10_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && !stop_evt) |=> (st == ST_RX));

    // R3: register contents change only after a write strobe
    a_r3_regs_need_write: assert property (@(posedge clk) disable iff (!rst_n)
        (regs != $past(regs)) |-> $past(wr_en));
endmodule

bind smb_blk_slave smb_blk_chk #(.NREG(NREG)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_lvl),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .sda_oe   (sda_oe_o),
    .wr_en    (wr_en),
    .regs     (regs_o),
    .st       (cur_st)
);

// File: tb/test_smb_blk_slave.sv
`timescale 1ns/1ps
module test_smb_blk_slave;
    localparam int NREG = 16;
    localparam int Q    = 10;   // system clocks per quarter bus period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic host_sda = 1'b1;
    logic sda_oe;
    logic sda_bus;
    logic [NREG*8-1:0] regs;

    always #10 clk = ~clk;   // 50 MHz

    assign sda_bus = host_sda & ~sda_oe;

    smb_blk_slave i_smb_blk_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl),
        .sda_i   (sda_bus),
        .sda_oe_o(sda_oe),
        .regs_o  (regs)
    );

    int checks = 0;
    int fails  = 0;
    int r9_viol = 0;
    bit done = 1'b0;
    logic oe_prev = 1'b0;

    // R9 monitor: drive must not move while the host holds SCL high
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl) r9_viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rv(input int i);
        return regs[i*8 +: 8];
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; tick(Q);
        scl = 1'b1;      tick(Q);
        host_sda = 1'b0; tick(Q);
        scl = 1'b0;      tick(Q);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; tick(Q);
        scl = 1'b1;      tick(Q);
        host_sda = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input bit b);
        host_sda = b; tick(Q);
        scl = 1'b1;   tick(2*Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        host_sda = 1'b1; tick(Q);
        scl = 1'b1;      tick(Q);
        acked = !sda_bus;
        tick(Q);
        scl = 1'b0;      tick(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        host_sda = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            b = {b[6:0], sda_bus};
            tick(Q);
            scl = 1'b0;
        end
        tick(Q);
        host_sda = give_ack ? 1'b0 : 1'b1; tick(Q);
        scl = 1'b1; tick(2*Q);
        scl = 1'b0; tick(Q);
        host_sda = 1'b1;
    endtask

    // write header plus data list; returns ack of every byte in order
    task automatic do_write(input logic [7:0] idx, input logic [7:0] cnt,
                            input logic [7:0] d0, input logic [7:0] d1, input int nd,
                            input string req);
        bit a;
        bus_start();
        send_byte(8'hD4, a); chk(a, {req, " addr D4 ack (R1)"}, a, 1);
        send_byte(idx, a);   chk(a, {req, " index ack (R3)"}, a, 1);
        send_byte(cnt, a);   chk(a, {req, " count ack (R3)"}, a, 1);
        if (nd > 0) begin send_byte(d0, a); chk(a, {req, " data0 ack (R3)"}, a, 1); end
        if (nd > 1) begin send_byte(d1, a); chk(a, {req, " data1 ack (R3)"}, a, 1); end
        bus_stop();
    endtask

    task automatic t_reset();
        bit all_zero = 1'b1;
        for (int i = 0; i < NREG; i++) if (rv(i) != 8'h00) all_zero = 1'b0;
        chk(all_zero, "R11 registers zero", all_zero, 1);
        chk(sda_oe == 1'b0, "R11 SDA released", sda_oe, 0);
    endtask

    task automatic t_basic_write();
        bit a;
        bus_start();
        send_byte(8'hD4, a); chk(a, "R1 write address acked", a, 1);
        send_byte(8'h03, a); chk(a, "R3 index acked", a, 1);
        send_byte(8'h03, a); chk(a, "R3 count acked", a, 1);
        send_byte(8'hA1, a); chk(a, "R3 byte 0 acked", a, 1);
        send_byte(8'hB2, a); chk(a, "R3 byte 1 acked", a, 1);
        send_byte(8'hC3, a); chk(a, "R3 byte 2 acked", a, 1);
        bus_stop();
        chk(rv(3) == 8'hA1, "R3 reg3", rv(3), 8'hA1);
        chk(rv(4) == 8'hB2, "R3 reg4", rv(4), 8'hB2);
        chk(rv(5) == 8'hC3, "R3 reg5", rv(5), 8'hC3);
        chk(regs[47:40] == 8'hC3, "R12 lane 5 bit position", regs[47:40], 8'hC3);
        chk(rv(2) == 8'h00 && rv(6) == 8'h00, "R3 neighbours untouched", {rv(2), rv(6)}, 0);
    endtask

    task automatic t_wrong_addr();
        bit a;
        bus_start();
        send_byte(8'hA0, a); chk(!a, "R2 foreign address not acked", a, 0);
        send_byte(8'h03, a); chk(!a, "R2 later byte not acked", a, 0);
        send_byte(8'hEE, a); chk(!a, "R2 later byte not acked", a, 0);
        bus_stop();
        chk(rv(3) == 8'hA1, "R2 reg3 unchanged", rv(3), 8'hA1);
        bus_start();
        send_byte(8'hD6, a); chk(!a, "R2 neighbour address not acked", a, 0);
        bus_stop();
    endtask

    task automatic t_overflow();
        bit a;
        bus_start();
        send_byte(8'hD4, a);
        send_byte(8'h06, a);
        send_byte(8'h01, a);
        send_byte(8'h11, a); chk(a, "R4 byte within count acked", a, 1);
        send_byte(8'h22, a); chk(!a, "R4 excess byte not acked", a, 0);
        send_byte(8'h33, a); chk(!a, "R4 slave stays off bus", a, 0);
        bus_stop();
        chk(rv(6) == 8'h11, "R4 reg6", rv(6), 8'h11);
        chk(rv(7) == 8'h00, "R4 reg7 not written", rv(7), 8'h00);
    endtask

    task automatic t_wrap_write();
        do_write(8'h0F, 8'h02, 8'h5A, 8'h6B, 2, "R5");
        chk(rv(15) == 8'h5A, "R5 reg15", rv(15), 8'h5A);
        chk(rv(0) == 8'h6B, "R5 wrapped into reg0", rv(0), 8'h6B);
    endtask

    task automatic t_read(input logic [7:0] idx, input logic [7:0] e1, input logic [7:0] e2,
                          input logic [7:0] e3);
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD4, a);
        send_byte(idx, a);   chk(a, "R6 index acked", a, 1);
        bus_start();
        send_byte(8'hD5, a); chk(a, "R1 read address acked", a, 1);
        recv_byte(1'b1, b);  chk(b == 8'h03, "R8 count byte from reg8", b, 8'h03);
        recv_byte(1'b1, b);  chk(b == e1, "R6 first register", b, e1);
        recv_byte(1'b1, b);  chk(b == e2, "R6 second register", b, e2);
        recv_byte(1'b0, b);  chk(b == e3, "R6 third register", b, e3);
        tick(4*Q);
        chk(sda_oe == 1'b0, "R7 released after host NACK", sda_oe, 0);
        // extra clock pulses must not bring data out
        put_bit(1'b1); put_bit(1'b1);
        chk(sda_oe == 1'b0, "R7 silent after NACK", sda_oe, 0);
        bus_stop();
    endtask

    task automatic t_abort();
        bit a;
        bus_start();
        send_byte(8'hD4, a);
        send_byte(8'h0A, a);
        send_byte(8'h04, a);
        send_byte(8'h77, a); chk(a, "R10 first byte acked", a, 1);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
        bus_stop();
        chk(rv(10) == 8'h77, "R10 written byte kept", rv(10), 8'h77);
        chk(rv(11) == 8'h00, "R10 partial byte dropped", rv(11), 8'h00);
        // start in the middle of a byte
        bus_start();
        send_byte(8'hD4, a);
        send_byte(8'h0C, a);
        send_byte(8'h02, a);
        send_byte(8'h55, a);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start();
        send_byte(8'hD4, a); chk(a, "R10 address after restart acked", a, 1);
        send_byte(8'h0D, a);
        send_byte(8'h01, a);
        send_byte(8'h66, a); chk(a, "R10 data after restart acked", a, 1);
        bus_stop();
        chk(rv(12) == 8'h55, "R10 reg12 kept", rv(12), 8'h55);
        chk(rv(13) == 8'h66, "R10 reg13 from new transfer", rv(13), 8'h66);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(5);
        t_reset();
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_basic_write();
        t_wrong_addr();
        t_overflow();
        t_wrap_write();
        // R8: set the read count register
        do_write(8'h08, 8'h01, 8'h03, 8'h00, 1, "R8");
        chk(rv(8) == 8'h03, "R8 count register written", rv(8), 8'h03);
        t_read(8'h03, 8'hA1, 8'hB2, 8'hC3);
        t_read(8'h0F, 8'h5A, 8'h6B, 8'h00);   // R5 wrap on read
        t_abort();
        chk(r9_viol == 0, "R9 drive moved while SCL high", r9_viol, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule